// File: doc/BRIEF.md
# TDM Output Enable and Control-Bit Serializer

This block drives the output side of a time-division switch that carries 32 channels on each of 8 serial transmit streams. Each transmit bit slot is one clock. A channel counter and a bit counter track the slot. Bits run from 7 down to 0, and each channel takes 8 clocks.

The block keeps a two-bit word for every stream and channel. The low bit of the word is the output enable for that stream in that channel. The high bit is a control bit that is shifted out on a single pin. The enable vector for the 8 streams is registered every slot. It is gated by a global enable input, and it is forced off while reset is high.

The control pin carries all 256 control bits once per frame, running one channel ahead of the transmit data. During each channel slot, the 8 bits of that slot carry the control bits of the following channel, ordered by stream. A frame-pulse input realigns the slot position to the start of a frame. A simple write port loads the per-channel words.

Top module: `tdm_oe_ctl_ser`

## Requirements
- R1: When `glob_oe` is low at a clock edge, every bit of `tx_oe` is 0 after that edge, whatever the stored enable bits are.
- R2: When `glob_oe` is high at a clock edge and reset is low, `tx_oe[s]` after that edge equals the enable bit stored for stream s in the channel of the new slot.
- R3: In the slot for channel N at bit position b, `ctl_out` equals the stored control bit of stream 7-b in channel (N+1) mod 32. The bit for stream 0, channel 0 is therefore sent in the slot for channel 31, bit 7.
- R4: Without reset or frame pulse, the bit position steps 7,6,...,0 on successive clocks. After bit 0 the position goes to bit 7 of the next channel, and channel 31 wraps to channel 0.
- R5: A clock edge with `frame_sync` high puts the block in the slot for channel 0, bit 7.
- R6: A clock edge with `rst` high sets `tx_oe` to all zeros and `ctl_out` to 0, and moves the slot to channel 0, bit 7.
- R7: `glob_oe` has no effect on the slot position or on `ctl_out`.
- R8: A write with `wr_en` high stores `wr_oe` and `wr_ctl` for (`wr_stream`, `wr_chan`). Outputs registered at the write edge still use the old word. Outputs from every later edge use the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one transmit bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync | input | 1 | Frame pulse; realigns the slot to channel 0, bit 7 |
| glob_oe | input | 1 | Global enable; low forces all streams to high impedance |
| wr_en | input | 1 | Write strobe for the per-channel word |
| wr_stream | input | 3 | Stream index of the write |
| wr_chan | input | 5 | Channel index of the write |
| wr_oe | input | 1 | Enable bit to store |
| wr_ctl | input | 1 | Control bit to store |
| tx_oe | output | 8 | Per-stream output-enable vector (1 = drive) |
| ctl_out | output | 1 | Serial control-bit output |

## Verification
The bench builds the block with its default 32 channels and 8 streams. At that size a full frame is 256 clocks, so it can run several complete frames. These frames include the wrap from channel 31 to channel 0 and the point where the control bit of stream 0, channel 0 appears in the last channel slot. Random frame pulses and resets inside a frame exercise realignment. The `glob_oe` input is toggled every clock to show that it changes only the enable vector.

// File: rtl/tdm_oe_ctl_ser.sv
module tdm_oe_ctl_ser #(
  parameter int NCH = 32,
  parameter int NST = 8,
  localparam int CW = $clog2(NCH),
  localparam int SW = $clog2(NST)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_sync,
  input  logic          glob_oe,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_stream,
  input  logic [CW-1:0] wr_chan,
  input  logic          wr_oe,
  input  logic          wr_ctl,
  output logic [NST-1:0] tx_oe,
  output logic          ctl_out
);

  localparam logic [SW-1:0] TOPBIT = SW'(NST - 1);

  logic [CW-1:0] ch_q, ch_d;
  logic [SW-1:0] bit_q, bit_d;
  logic [NCH-1:0] oe_mem [NST];
  logic [NCH-1:0] cc_mem [NST];
  logic [NST-1:0] en_d;

  always_comb begin
    if (rst || frame_sync) begin
      ch_d  = '0;
      bit_d = TOPBIT;
    end else if (bit_q == '0) begin
      ch_d  = ch_q + CW'(1);
      bit_d = TOPBIT;
    end else begin
      ch_d  = ch_q;
      bit_d = bit_q - SW'(1);
    end
  end

  wire [CW-1:0] ch_ahead = ch_d + CW'(1);
  wire [SW-1:0] ctl_str  = TOPBIT - bit_d;

  always_comb
    for (int s = 0; s < NST; s++) en_d[s] = glob_oe & oe_mem[s][ch_d];

  always_ff @(posedge clk) begin
    ch_q  <= ch_d;
    bit_q <= bit_d;
    if (rst) begin
      tx_oe   <= '0;
      ctl_out <= 1'b0;
    end else begin
      tx_oe   <= en_d;
      ctl_out <= cc_mem[ctl_str][ch_ahead];
    end
  end

  always_ff @(posedge clk)
    if (wr_en) begin
      oe_mem[wr_stream][wr_chan] <= wr_oe;
      cc_mem[wr_stream][wr_chan] <= wr_ctl;
    end

  a_r6_reset_quiet: assert property (@(posedge clk)
    rst |=> (tx_oe == '0) && !ctl_out && (ch_q == '0) && (bit_q == TOPBIT));

  a_r1_global_off: assert property (@(posedge clk) disable iff (rst)
    !glob_oe |=> tx_oe == '0);

  a_r4_bit_descends: assert property (@(posedge clk) disable iff (rst)
    (!frame_sync && bit_q != '0) |=> (bit_q == $past(bit_q) - SW'(1)) && $stable(ch_q));

  a_r4_chan_steps: assert property (@(posedge clk) disable iff (rst)
    (!frame_sync && bit_q == '0) |=> (ch_q == $past(ch_q) + CW'(1)) && (bit_q == TOPBIT));

  a_r5_frame_align: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> (ch_q == '0) && (bit_q == TOPBIT));

endmodule

// File: tb/tdm_oe_ctl_ser_bench.sv
module tdm_oe_ctl_ser_bench;
  localparam int PERIOD = 10;
  localparam int NCH = 32;
  localparam int NST = 8;

  logic clk = 0, rst = 1, frame_sync = 0, glob_oe = 0, wr_en = 0, wr_oe = 0, wr_ctl = 0;
  logic [2:0] wr_stream = 0;
  logic [4:0] wr_chan = 0;
  logic [7:0] tx_oe;
  logic ctl_out;

  tdm_oe_ctl_ser #(.NCH(NCH), .NST(NST)) u_tdm_oe_ctl_ser (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .glob_oe(glob_oe),
    .wr_en(wr_en), .wr_stream(wr_stream), .wr_chan(wr_chan),
    .wr_oe(wr_oe), .wr_ctl(wr_ctl), .tx_oe(tx_oe), .ctl_out(ctl_out));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int ech = 0, ebit = 7;
  bit m_oe [NST][NCH];
  bit m_cc [NST][NCH];

  function automatic logic [7:0] exp_oe(bit r, bit o, int ch);
    logic [7:0] v = '0;
    if (!r && o) for (int s = 0; s < NST; s++) v[s] = m_oe[s][ch];
    return v;
  endfunction

  function automatic logic exp_ctl(bit r, int ch, int b);
    if (r) return 1'b0;
    return m_cc[NST-1-b][(ch + 1) % NCH];
  endfunction

  task automatic step(bit r, bit f, bit o, bit w, int ws, int wc, bit wo, bit wcv,
                      string t_oe, string t_ctl);
    logic [7:0] eo;
    logic ec;
    rst = r; frame_sync = f; glob_oe = o; wr_en = w;
    wr_stream = 3'(ws); wr_chan = 5'(wc); wr_oe = wo; wr_ctl = wcv;
    @(posedge clk);
    if (r || f) begin ech = 0; ebit = 7; end
    else if (ebit == 0) begin ech = (ech + 1) % NCH; ebit = 7; end
    else ebit = ebit - 1;
    eo = exp_oe(r, o, ech);
    ec = exp_ctl(r, ech, ebit);
    if (w) begin m_oe[ws][wc] = wo; m_cc[ws][wc] = wcv; end
    @(negedge clk);
    checks++;
    if (tx_oe !== eo) begin
      errors++;
      $display("FAIL %s tx_oe ch%0d bit%0d actual %h expected %h", t_oe, ech, ebit, tx_oe, eo);
    end
    checks++;
    if (ctl_out !== ec) begin
      errors++;
      $display("FAIL %s ctl_out ch%0d bit%0d actual %b expected %b", t_ctl, ech, ebit, ctl_out, ec);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R6: reset state
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, 0, 0, 0, "R6", "R6");
    // R8: load every word while the global enable is off (R1)
    for (int s = 0; s < NST; s++)
      for (int c = 0; c < NCH; c++)
        step(0, 0, 0, 1, s, c, 1'($urandom), 1'($urandom), "R1,R8", "R3");
    // R5: frame alignment
    step(0, 1, 1, 0, 0, 0, 0, 0, "R5", "R5");
    // R2 R3 R4: random run with occasional frame pulses
    for (int i = 0; i < 700; i++) begin
      bit o = ($urandom % 4) != 0;
      bit f = ($urandom % 97) == 0;
      step(0, f, o, 0, 0, 0, 0, 0, o ? "R2" : "R1", "R3,R4");
    end
    // R3 corner: distinct pattern for channel 0, checked through the wrap 31 -> 0
    for (int s = 0; s < NST; s++) step(0, 0, 1, 1, s, 0, 1'(s), 1'((8'hA5 >> s) & 1), "R2", "R3");
    step(0, 1, 1, 0, 0, 0, 0, 0, "R5", "R5");
    for (int i = 0; i < 2 * NCH * NST; i++) step(0, 0, 1, 0, 0, 0, 0, 0, "R2", "R3,R4");
    // R7: global enable toggles every clock, control stream unaffected
    for (int i = 0; i < 300; i++) step(0, 0, 1'(i & 1), 0, 0, 0, 0, 0, (i & 1) ? "R2" : "R1", "R7");
    // R8: writes while running, including the channel about to be sent
    for (int i = 0; i < 400; i++) begin
      int wc = ($urandom % 3 == 0) ? (ech + 1) % NCH : int'($urandom % NCH);
      step(0, 0, 1, 1, int'($urandom % NST), wc, 1'($urandom), 1'($urandom), "R8", "R8");
    end
    // R6: reset in mid-frame, then resume
    step(1, 0, 1, 0, 0, 0, 0, 0, "R6", "R6");
    for (int i = 0; i < 300; i++) step(0, 0, 1, 0, 0, 0, 0, 0, "R2", "R3,R6");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule